// File: doc/BRIEF.md
# Self-Clocked Serial ADC Receiver

This block sits on the host side of a serial converter link in which the converter returns each result on a single data line. The host supplies a burst clock, and every result is framed by an in-band header. The header is a '1' followed by a '0', and it precedes sixteen result bits sent most significant first. The loop delay from the host's burst clock to the returning data line is not known in advance. It can also drift by several clock periods between converters. For that reason the receiver measures the delay again for every word.

The receiver runs on a fabric clock three times the burst clock rate, so each serial bit spans three consecutive samples. When `arm` reports that a burst has started, a three-phase counter restarts and the receiver hunts for the first '1'. The phase at which that '1' appears fixes the sampling phase for the rest of the word: the phase that follows it, which is the centre of every later bit. The receiver then confirms the header, shifts in the sixteen data bits and presents the result with a one-cycle strobe.

An optional mode expects one extra '0' bit period before the header, giving 19 bit periods per frame. A programmable limit bounds the hunt. Each frame ends in exactly one of three outcomes: a result, a header error or a timeout.

Top module: `ssr_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rx_valid`, `hdr_err` and `tmo_err` are 0 and `lock_phase` is 0.
- R2: A high `arm` in the idle state starts a hunt and restarts the phase counter at phase 0. A high `arm` while a word is being received has no effect on that word.
- R3: If the first '1' is sampled in hunt cycle k (counted from 0 after the arming edge), `lock_phase` becomes (k+1) mod 3. It stays unchanged until the next hunt.
- R4: The header '1' must still be present at the chosen phase one cycle after detection, and the next bit sampled three cycles later must be '0'. Otherwise `hdr_err` pulses for one cycle, no result is produced and the receiver returns to idle.
- R5: After a valid header, sixteen bits are sampled every third cycle at the chosen phase. They are assembled with the first bit as bit 15, and `rx_data` is presented with `rx_valid` high for exactly one cycle.
- R6: With `lead_zero` high at arming, a '1' in the first burst period (hunt cycles 0 to 2) causes a header error. A '1' after that is accepted, so a frame with one leading zero bit decodes correctly.
- R7: If no '1' is seen during the first `tmo_limit` burst periods of a hunt, `tmo_err` pulses for one cycle and the receiver returns to idle without a result. A '1' in period `tmo_limit`-1 is still accepted.
- R8: In any cycle at most one of `rx_valid`, `hdr_err` and `tmo_err` is high.
- R9: Alignment is redone for every frame, so back-to-back frames with different delays each decode with their own phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, three times the burst clock rate |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Burst has started; begins a hunt when idle |
| lead_zero | input | 1 | Expect one extra leading zero bit period (latched at arming) |
| tmo_limit | input | TW | Hunt limit in burst periods |
| sdata | input | 1 | Returning serial data line, already synchronised |
| rx_data | output | DW | Last received result |
| rx_valid | output | 1 | One-cycle strobe with a new result |
| lock_phase | output | 2 | Sampling phase chosen for the current word |
| hdr_err | output | 1 | One-cycle pulse on a malformed header |
| tmo_err | output | 1 | One-cycle pulse when the hunt expires |

## Verification
The assertions assume that every serial bit on `sdata` is held for exactly three fabric cycles, with its edges on fabric clock edges. They also assume that `lead_zero` and `tmo_limit` do not change during a frame. The bench converter model follows these rules. It drives each bit at a falling fabric edge for three cycles and offsets the frame by a random whole number of cycles. It changes the mode and the limit only between frames, and it picks offsets that stay inside the hunt limit unless a timeout is the intended outcome.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_RECV = 2'd2
  } rx_state_t;

  localparam int PHASES = 3;
endpackage

// File: rtl/ssr_phase_track.sv
module ssr_phase_track #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          hunt,
  input  logic          din,
  input  logic          lead_zero,
  input  logic [TW-1:0] tmo_limit,
  output logic          found,
  output logic          early_one,
  output logic          timeout,
  output logic          tick,
  output logic [1:0]    sel_q
);
  import ssr_pkg::*;
  localparam logic [1:0] PH_LAST = 2'(PHASES - 1);

  logic [1:0]    ph_q;
  logic [TW-1:0] pc_q;
  logic          lz_q;
  logic          wrap;
  logic          masked;
  logic [TW:0]   pc_next;

  assign wrap      = (ph_q == PH_LAST);
  assign masked    = lz_q && (pc_q == '0);
  assign pc_next   = {1'b0, pc_q} + (TW+1)'(1);
  assign found     = hunt && din && !masked;
  assign early_one = hunt && din && masked;
  assign timeout   = hunt && !din && wrap && (pc_next >= {1'b0, tmo_limit});
  assign tick      = (ph_q == sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      pc_q  <= '0;
      lz_q  <= 1'b0;
      sel_q <= '0;
    end else if (start) begin
      ph_q  <= '0;
      pc_q  <= '0;
      lz_q  <= lead_zero;
    end else begin
      ph_q <= wrap ? 2'd0 : ph_q + 2'd1;
      if (hunt && wrap) pc_q <= pc_next[TW-1:0];
      if (found) sel_q <= wrap ? 2'd0 : ph_q + 2'd1;
    end
  end

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (rst)
    ph_q != 2'd3);

  assert_sel_range_R3: assert property (@(posedge clk) disable iff (rst)
    sel_q != 2'd3);

  assert_restart_phase_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (ph_q == 2'd0));
endmodule

// File: rtl/ssr_deser.sv
module ssr_deser #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          tick,
  input  logic          din,
  output logic          hdr_bad,
  output logic          done,
  output logic [DW-1:0] data_q,
  output logic          valid_q
);
  localparam int            IW   = $clog2(DW + 2);
  localparam logic [IW-1:0] LAST = IW'(DW + 1);
  localparam logic [IW-1:0] HDR1 = IW'(0);
  localparam logic [IW-1:0] HDR2 = IW'(1);

  logic [IW-1:0] idx_q;
  logic [DW-1:0] sh_q;
  logic [DW-1:0] sh_next;

  assign sh_next = {sh_q[DW-2:0], din};
  assign hdr_bad = tick && (((idx_q == HDR1) && !din) || ((idx_q == HDR2) && din));
  assign done    = tick && (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (load) begin
        idx_q <= '0;
      end else if (tick && !hdr_bad && (idx_q != LAST)) begin
        idx_q <= idx_q + IW'(1);
      end
      if (tick && (idx_q > HDR2)) sh_q <= sh_next;
      if (done) begin
        data_q  <= sh_next;
        valid_q <= 1'b1;
      end
    end
  end

  assert_index_bound_R5: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
endmodule

// File: rtl/ssr_rx.sv
module ssr_rx #(
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          lead_zero,
  input  logic [TW-1:0] tmo_limit,
  input  logic          sdata,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic [1:0]    lock_phase,
  output logic          hdr_err,
  output logic          tmo_err
);
  import ssr_pkg::*;

  rx_state_t st_q;
  logic start, hunt, recv_tick;
  logic found, early_one, timeout, tick;
  logic hdr_bad, done;

  assign start     = (st_q == ST_IDLE) && arm;
  assign hunt      = (st_q == ST_HUNT);
  assign recv_tick = (st_q == ST_RECV) && tick;

  ssr_phase_track #(.TW(TW)) track_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .hunt      (hunt),
    .din       (sdata),
    .lead_zero (lead_zero),
    .tmo_limit (tmo_limit),
    .found     (found),
    .early_one (early_one),
    .timeout   (timeout),
    .tick      (tick),
    .sel_q     (lock_phase)
  );

  ssr_deser #(.DW(DW)) deser_i (
    .clk     (clk),
    .rst     (rst),
    .load    (found),
    .tick    (recv_tick),
    .din     (sdata),
    .hdr_bad (hdr_bad),
    .done    (done),
    .data_q  (rx_data),
    .valid_q (rx_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      hdr_err <= 1'b0;
      tmo_err <= 1'b0;
    end else begin
      hdr_err <= 1'b0;
      tmo_err <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (arm) st_q <= ST_HUNT;
        ST_HUNT: begin
          if (found) begin
            st_q <= ST_RECV;
          end else if (early_one) begin
            st_q    <= ST_IDLE;
            hdr_err <= 1'b1;
          end else if (timeout) begin
            st_q    <= ST_IDLE;
            tmo_err <= 1'b1;
          end
        end
        ST_RECV: begin
          if (hdr_bad) begin
            st_q    <= ST_IDLE;
            hdr_err <= 1'b1;
          end else if (done) begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_valid, hdr_err, tmo_err}));

  assert_tmo_from_hunt_R7: assert property (@(posedge clk) disable iff (rst)
    tmo_err |-> ($past(st_q) == ST_HUNT));

  assert_valid_from_recv_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(st_q) == ST_RECV));

  assert_arm_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_RECV) && arm) |=> (st_q != ST_HUNT));

  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_RECV) && ($past(st_q) == ST_RECV)) |-> $stable(lock_phase));

  assert_hdr_err_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    hdr_err |=> !hdr_err);
endmodule

// File: tb/ssr_rx_tb_top.sv
module ssr_rx_tb_top;
  localparam int DW = 16;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arm = 1'b0;
  logic          lead_zero = 1'b0;
  logic [TW-1:0] tmo_limit = 8'd8;
  logic          sdata = 1'b0;
  logic [DW-1:0] rx_data;
  logic          rx_valid;
  logic [1:0]    lock_phase;
  logic          hdr_err;
  logic          tmo_err;

  always #2.5 clk = ~clk;

  ssr_rx #(.DW(DW), .TW(TW)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .lead_zero  (lead_zero),
    .tmo_limit  (tmo_limit),
    .sdata      (sdata),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .lock_phase (lock_phase),
    .hdr_err    (hdr_err),
    .tmo_err    (tmo_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int ev_valid = 0, ev_hdr = 0, ev_tmo = 0;
  logic [DW-1:0] got_data = '0;
  logic [1:0]    got_ph = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        ev_valid++;
        got_data = rx_data;
        got_ph   = lock_phase;
      end
      if (hdr_err) ev_hdr++;
      if (tmo_err) ev_tmo++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_phase(input int gap, input bit pz);
    return (gap + (pz ? 3 : 0) + 1) % 3;
  endfunction

  // kind: 0 result, 1 header error, 2 timeout
  task automatic frame(input string req, input int gap, input bit lz_cfg,
                       input bit put_zero, input bit [1:0] hdr,
                       input bit [DW-1:0] w, input bit glitch,
                       input bit rearm, input bit nobits, input int kind);
    logic bits [0:19];
    int n = 0;
    int v0 = ev_valid;
    int h0 = ev_hdr;
    int t0 = ev_tmo;
    if (put_zero) begin bits[n] = 1'b0; n++; end
    bits[n] = hdr[1]; n++;
    bits[n] = hdr[0]; n++;
    for (int i = DW - 1; i >= 0; i--) begin bits[n] = w[i]; n++; end
    if (nobits || glitch) n = 0;
    @(negedge clk);
    arm = 1'b1;
    lead_zero = lz_cfg;
    @(negedge clk);
    arm = 1'b0;
    for (int i = 0; i < gap; i++) begin sdata = 1'b0; @(negedge clk); end
    if (glitch) begin sdata = 1'b1; @(negedge clk); sdata = 1'b0; end
    for (int b = 0; b < n; b++) begin
      for (int c = 0; c < 3; c++) begin
        sdata = bits[b];
        arm = (rearm && b == 10 && c == 0);
        @(negedge clk);
      end
    end
    sdata = 1'b0;
    arm = 1'b0;
    repeat (40) @(negedge clk);
    if (kind == 0) begin
      check(ev_valid - v0 == 1, req, "result strobes", ev_valid - v0, 1);
      check(got_data == w, req, "rx_data", got_data, w);
      check(got_ph == 2'(exp_phase(gap, put_zero)), req, "lock_phase", got_ph,
            exp_phase(gap, put_zero));
      check(ev_hdr - h0 + ev_tmo - t0 == 0, req, "error pulses",
            ev_hdr - h0 + ev_tmo - t0, 0);
    end else if (kind == 1) begin
      check(ev_hdr - h0 == 1, req, "hdr_err pulses", ev_hdr - h0, 1);
      check(ev_valid - v0 == 0, req, "result strobes", ev_valid - v0, 0);
    end else begin
      check(ev_tmo - t0 == 1, req, "tmo_err pulses", ev_tmo - t0, 1);
      check(ev_valid - v0 == 0, req, "result strobes", ev_valid - v0, 0);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check(rx_valid == 0 && hdr_err == 0 && tmo_err == 0, "R1", "flags in reset",
          {rx_valid, hdr_err, tmo_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rx_valid == 0 && hdr_err == 0 && tmo_err == 0 && lock_phase == 0,
          "R1", "state after reset", {rx_valid, hdr_err, tmo_err, lock_phase}, 0);

    // R5, R3: directed offsets covering each phase
    frame("R5", 0, 0, 0, 2'b10, 16'hA5C3, 0, 0, 0, 0);
    frame("R3", 1, 0, 0, 2'b10, 16'h8001, 0, 0, 0, 0);
    frame("R3", 2, 0, 0, 2'b10, 16'hFFFF, 0, 0, 0, 0);
    frame("R5", 5, 0, 0, 2'b10, 16'h0000, 0, 0, 0, 0);
    // R2: arm during reception ignored
    frame("R2", 4, 0, 0, 2'b10, 16'h1234, 0, 1, 0, 0);
    // R4: bad second header bit, then a one-cycle glitch
    frame("R4", 3, 0, 0, 2'b11, 16'h5555, 0, 0, 0, 1);
    frame("R4", 2, 0, 0, 2'b10, 16'h0000, 1, 0, 0, 1);
    // R6: leading zero mode
    frame("R6", 2, 1, 1, 2'b10, 16'hBEEF, 0, 0, 0, 0);
    frame("R6", 1, 1, 0, 2'b10, 16'hBEEF, 0, 0, 0, 1);
    // R7: timeout boundary with a limit of three periods
    tmo_limit = 8'd3;
    frame("R7", 6, 0, 0, 2'b10, 16'hC0DE, 0, 0, 0, 0);
    frame("R7", 9, 0, 0, 2'b10, 16'hC0DE, 0, 0, 0, 2);
    frame("R7", 0, 0, 0, 2'b10, 16'h0000, 0, 0, 1, 2);
    tmo_limit = 8'd8;
    // R9, R8: random back-to-back frames with changing delay and mode
    for (int k = 0; k < 24; k++) begin
      int g = $urandom_range(0, 14);
      bit lz = 1'($urandom % 2);
      bit [DW-1:0] w = DW'($urandom);
      frame("R9", g, lz, lz, 2'b10, w, 0, 0, 0, 0);
    end
    finish_run();
  end
endmodule